// File: doc/BRIEF.md
# Signed-Distance Bidirectional Shifter

This block shifts a 16-bit data word by a distance and in a direction that both come from one signed control word. The sign bit of the control word chooses the direction: set means shift right, clear means shift left. The four least significant control bits give the distance, from 0 to 15. Every other control bit is ignored. An operation select picks logical or arithmetic behaviour. The two operations differ only for right shifts. There the arithmetic form copies the data's sign bit into the vacated high positions, and the logical form fills them with zeros. Left shifts always fill zeros from the bottom.

Along with the shifted word, the block produces a three-bit condition code in which exactly one flag is set. The flag says whether the result is negative, zero or positive. The operands arrive already selected. The shifter and the flag logic are combinational, and one register stage holds the result. The output stage is a two-state machine. ST_EMPTY means no fresh result is present. ST_FULL means the result register was loaded on the previous clock edge. The transition LOAD goes from either state to ST_FULL when `in_valid` is high. The transition DRAIN goes from either state to ST_EMPTY when `in_valid` is low. Reset enters ST_EMPTY.

Top module: `shift_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high, and low in the cycle after an edge at which `in_valid` was low.
- R2: With control bit 15 clear, the result is the data shifted left by control bits 3:0, with zeros entering at bit 0. The result is the same for `op_arith` 0 and 1.
- R3: With control bit 15 set and `op_arith` = 0, the result is the data shifted right by control bits 3:0, with zeros entering at bit 15.
- R4: With control bit 15 set and `op_arith` = 1, the result is the data shifted right by control bits 3:0, with every vacated high bit equal to data bit 15.
- R5: When control bits 3:0 are zero, the result equals the data word, whatever the direction and the operation.
- R6: Control bits 14:4 have no effect on the result or on the condition code.
- R7: `cc` has exactly one bit set. `cc[2]` (N) is set when result bit 15 is 1. `cc[1]` (Z) is set when the result is all zeros. `cc[0]` (P) is set otherwise.
- R8: When `in_valid` is low at a clock edge, `result` and `cc` keep their values.
- R9: While `rst_n` is low, `out_valid` = 0, `result` = 0 and `cc` = 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| op_arith | input | 1 | 1 selects arithmetic, 0 selects logical |
| data_in | input | 16 | Word to be shifted |
| ctrl_in | input | 16 | Signed shift control: bit 15 is the direction, bits 3:0 the distance |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 16 | Shifted word |
| cc | output | 3 | Condition code {N, Z, P}, one-hot |

## Verification
The result, the condition code and `out_valid` all appear one clock after the edge that samples `in_valid` high, because each of them passes through exactly one register. The bench therefore drives operands on a falling edge and checks the outputs on the following falling edge, half a period after the capturing rising edge. The hold behaviour is checked the same way. The bench lowers `in_valid`, changes the operands, and confirms on the next falling edge that `result` and `cc` have not moved.

// File: rtl/shift_pkg.sv
package shift_pkg;

    localparam int DATA_W = 16;
    localparam int MAG_W  = 4;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    typedef enum logic {
        OP_LOGIC = 1'b0,
        OP_ARITH = 1'b1
    } shift_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;

    typedef struct packed {
        shift_dir_e          dir;
        logic [MAG_W-1:0]    mag;
    } shift_cmd_t;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } cond_code_t;

endpackage

// File: rtl/shift_ctrl_decode.sv
module shift_ctrl_decode
    import shift_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int MW  = MAG_W
) (
    input  logic [W-1:0] ctrl_in,
    output shift_cmd_t   cmd
);
    localparam int SIGN_BIT = W - 1;

    // Only the sign bit and the distance field take part; the rest is dropped.
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^ctrl_in[SIGN_BIT-1:MW];

    always_comb begin
        cmd.dir = ctrl_in[SIGN_BIT] ? DIR_RIGHT : DIR_LEFT;
        cmd.mag = ctrl_in[MW-1:0];
    end
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
    import shift_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int MW = MAG_W
) (
    input  logic [W-1:0] data_in,
    input  shift_cmd_t   cmd,
    input  shift_op_e    op,
    output logic [W-1:0] data_out
);
    logic         fill;
    logic [W-1:0] stage [MW+1];

    assign fill     = (op == OP_ARITH) ? data_in[W-1] : 1'b0;
    assign stage[0] = data_in;

    // One stage per distance bit, each moving by a power of two.
    for (genvar k = 0; k < MW; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [W-1:0] l_val;
        logic [W-1:0] r_val;
        assign l_val        = {stage[k][W-1-S:0], {S{1'b0}}};
        assign r_val        = {{S{fill}}, stage[k][W-1:S]};
        assign stage[k+1]   = !cmd.mag[k]            ? stage[k] :
                              (cmd.dir == DIR_RIGHT) ? r_val    : l_val;
    end

    assign data_out = stage[MW];
endmodule

// File: rtl/shift_cc_gen.sv
module shift_cc_gen
    import shift_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] value,
    output cond_code_t   code
);
    logic is_zero;
    assign is_zero = (value == '0);

    always_comb begin
        code.n = value[W-1];
        code.z = is_zero;
        code.p = !value[W-1] && !is_zero;
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int MW = MAG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         op_arith,
    input  logic [15:0]  data_in,
    input  logic [15:0]  ctrl_in,
    output logic         out_valid,
    output logic [15:0]  result,
    output logic [2:0]   cc
);
    shift_cmd_t   cmd;
    shift_op_e    op_sel;
    logic [W-1:0] shifted;
    cond_code_t   code_next;
    out_state_e   state_q;
    out_state_e   state_d;

    assign op_sel = op_arith ? OP_ARITH : OP_LOGIC;

    shift_ctrl_decode #(.W(W), .MW(MW)) u_decode (
        .ctrl_in (ctrl_in),
        .cmd     (cmd)
    );

    shift_barrel #(.W(W), .MW(MW)) u_barrel (
        .data_in  (data_in),
        .cmd      (cmd),
        .op       (op_sel),
        .data_out (shifted)
    );

    shift_cc_gen #(.W(W)) u_cc (
        .value (shifted),
        .code  (code_next)
    );

    // Next-state: LOAD on a valid input, DRAIN otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            cc     <= 3'b010;
        end else if (in_valid) begin
            result <= shifted;
            cc     <= {code_next.n, code_next.z, code_next.p};
        end
    end

    assign out_valid = (state_q == ST_FULL);
endmodule

// File: rtl/shift_unit_checker.sv
module shift_unit_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        op_arith,
    input logic [15:0] data_in,
    input logic [15:0] ctrl_in,
    input logic        out_valid,
    input logic [15:0] result,
    input logic [2:0]  cc
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_left_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctrl_in[15] && ctrl_in[3:0] != 4'd0) |=> !result[0]);
    p_right_logic_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl_in[15] && !op_arith && ctrl_in[3:0] != 4'd0) |=> !result[15]);
    p_right_arith_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl_in[15] && op_arith) |=> (result[15] == $past(data_in[15])));
    p_zero_distance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl_in[3:0] == 4'd0) |=> (result == $past(data_in)));
    p_cc_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc) == 1);
    p_cc_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (result == 16'd0) |-> (cc == 3'b010));
    p_cc_negative_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result[15] |-> (cc == 3'b100));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(cc)));
endmodule

bind shift_unit shift_unit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_arith  (op_arith),
    .data_in   (data_in),
    .ctrl_in   (ctrl_in),
    .out_valid (out_valid),
    .result    (result),
    .cc        (cc)
);

// File: tb/shift_unit_test.sv
module shift_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_arith = 1'b0;
    logic [15:0] data_in = '0;
    logic [15:0] ctrl_in = '0;
    logic        out_valid;
    logic [15:0] result;
    logic [2:0]  cc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shift_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_arith(op_arith),
        .data_in(data_in), .ctrl_in(ctrl_in), .out_valid(out_valid),
        .result(result), .cc(cc)
    );

    function automatic logic [15:0] ref_shift(input logic [15:0] d,
                                              input logic [15:0] c,
                                              input logic arith);
        logic [15:0] r;
        int m;
        m = int'(c[3:0]);
        for (int i = 0; i < 16; i++) begin
            if (!c[15]) r[i] = (i - m >= 0) ? d[i-m] : 1'b0;
            else        r[i] = (i + m <= 15) ? d[i+m] : (arith ? d[15] : 1'b0);
        end
        return r;
    endfunction

    function automatic logic [2:0] ref_cc(input logic [15:0] v);
        if (v[15])        return 3'b100;
        else if (v == 0)  return 3'b010;
        else              return 3'b001;
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_one(input logic [15:0] d, input logic [15:0] c,
                           input logic arith, input string tag);
        logic [15:0] e;
        @(negedge clk);
        data_in = d; ctrl_in = c; op_arith = arith; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        e = ref_shift(d, c, arith);
        check({tag, " result"}, result, e);
        check("R7 cc", {13'd0, cc}, {13'd0, ref_cc(e)});
        check("R1 out_valid", {15'd0, out_valid}, 16'd1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held_r;
        logic [2:0]  held_c;
        void'($urandom(32'h5eed_0421));

        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 out_valid", {15'd0, out_valid}, 16'd0);
        check("R9 result", result, 16'd0);
        check("R9 cc", {13'd0, cc}, 16'd2);
        rst_n = 1'b1;

        // Directed corners
        run_one(16'h8001, 16'h000F, 1'b0, "R2 left 15");
        run_one(16'h8001, 16'h000F, 1'b1, "R2 left 15 arith");
        run_one(16'h8000, 16'h800F, 1'b1, "R4 right 15 arith");
        run_one(16'h8000, 16'h800F, 1'b0, "R3 right 15 logic");
        run_one(16'hB5A3, 16'h0000, 1'b0, "R5 zero left logic");
        run_one(16'hB5A3, 16'h8000, 1'b1, "R5 zero right arith");
        run_one(16'hB5A3, 16'h7FF3, 1'b0, "R6 ignored bits left");
        run_one(16'hB5A3, 16'hFFF2, 1'b1, "R6 ignored bits right arith");
        run_one(16'h00F0, 16'h0010, 1'b0, "R6 bit4 only");
        run_one(16'h0001, 16'h8001, 1'b0, "R7 zero result");

        // R1: valid drops after an idle edge
        @(negedge clk);
        check("R1 out_valid idle", {15'd0, out_valid}, 16'd0);

        // R8: hold while in_valid is low
        held_r = result; held_c = cc;
        data_in = 16'h1234; ctrl_in = 16'h0004; op_arith = 1'b0;
        @(negedge clk);
        check("R8 hold result", result, held_r);
        check("R8 hold cc", {13'd0, cc}, {13'd0, held_c});

        // Random sweep of all four direction/operation pairs
        for (int i = 0; i < 400; i++) begin
            logic [15:0] d, c;
            logic a;
            d = 16'($urandom);
            c = 16'($urandom);
            a = 1'($urandom);
            if (i % 10 == 0) c[3:0] = 4'd15;
            if (i % 10 == 1) c[3:0] = 4'd0;
            if (c[3:0] == 4'd0)      run_one(d, c, a, "R5 random zero");
            else if (!c[15])         run_one(d, c, a, "R2 random left");
            else if (a)              run_one(d, c, a, "R4 random arith right");
            else                     run_one(d, c, a, "R3 random logic right");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule